// File: doc/BRIEF.md
# Dual-Bank X/Y Data Memory

This block is a byte-addressed data store cut at a fixed boundary into two regions. Addresses below the boundary form the X region, and addresses from the boundary up to the implemented size form the Y region. Ordinary accesses treat both regions as one flat space. Reads use the X read port, and writes use the single write port.

Dual-operand multiply-accumulate cycles work differently. They fetch one word from the X region and one word from the Y region in the same clock, each on its own address and data path. If either dual operand points into the wrong region, the cycle is flagged. Address arithmetic lives outside this block: it receives 16-bit effective addresses that are already final.

Top module: `xy_data_mem`

## Requirements
- R1: While reset is active, and on the first cycle after it, `x_rdata`, `y_rdata` and `addr_error` are zero.
- R2: A single-mode X read (`dual`=0, `x_rd_en`=1) returns, one clock later on `x_rdata`, the 16-bit word at `x_addr[15:1]`. It can reach any implemented address, in either region, and address bit 0 is ignored.
- R3: A word write (`wr_en`=1, `wr_byte`=0) stores all 16 bits of `wr_data` at word `wr_addr[15:1]` in the unified space, and bit 0 of the address is ignored.
- R4: A byte write (`wr_byte`=1) stores `wr_data[7:0]` into bits 7:0 of the word when `wr_addr[0]`=0, or into bits 15:8 when `wr_addr[0]`=1. The other byte of the word is left unchanged.
- R5: Addresses at or above `MEM_BYTES` read as zero. Writes to them are ignored and do not alias onto any implemented word.
- R6: In a dual cycle (`dual`=1), the X and Y read ports each return their word one clock later, both in the same cycle.
- R7: In a dual cycle, an enabled X address at or above `Y_BASE`, or an enabled Y address below `Y_BASE`, drives `addr_error` high one clock later and returns zero on the offending port. The other port still returns normal data. `addr_error` is low after any cycle with no such fault.
- R8: A read and a write to the same word in the same cycle return the word's previous contents. The new value is seen by the next read.
- R9: `x_rdata` holds its value when `x_rd_en` is low. `y_rdata` holds its value unless `dual` and `y_rd_en` are both high, so a Y read request outside a dual cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the read registers |
| dual | input | 1 | Marks a dual-operand read cycle |
| x_rd_en | input | 1 | X read port request |
| x_addr | input | 16 | X read byte address |
| y_rd_en | input | 1 | Y read port request (acted on only when `dual` is high) |
| y_addr | input | 16 | Y read byte address |
| wr_en | input | 1 | Write request |
| wr_byte | input | 1 | 1 = byte write, 0 = word write |
| wr_addr | input | 16 | Write byte address |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| x_rdata | output | 16 | X port read data, one cycle latency |
| y_rdata | output | 16 | Y port read data, one cycle latency |
| addr_error | output | 1 | Dual-read region fault, one cycle latency |

## Verification
Random traffic is spread over four address classes: inside X, inside Y, above the implemented size, and anywhere in a 13-bit window. Single and dual cycles are mixed with word and byte writes. This separates routing faults, wrong region boundaries and wrong size limits, because each class gives a different expected word, zero or error.

Directed cases add the following checks:
- odd addresses, which show whether bit 0 leaks into the word select;
- paired byte writes to one word, which show lane selection and preservation of the other byte;
- a write above the size followed by a read of the low alias;
- a same-word read and write, which shows the old-data ordering;
- idle and misrouted Y requests, which show the hold behaviour.

// File: rtl/xy_data_mem.sv
`timescale 1ns/1ps
module xy_data_mem #(
  parameter int MEM_BYTES = 4096,
  parameter int Y_BASE    = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dual,
  input  logic        x_rd_en,
  input  logic [15:0] x_addr,
  input  logic        y_rd_en,
  input  logic [15:0] y_addr,
  input  logic        wr_en,
  input  logic        wr_byte,
  input  logic [15:0] wr_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] x_rdata,
  output logic [15:0] y_rdata,
  output logic        addr_error
);
  localparam int XW = Y_BASE / 2;
  localparam int YW = (MEM_BYTES - Y_BASE) / 2;
  localparam int XA = $clog2(XW);
  localparam int YA = $clog2(YW);
  localparam logic [16:0] YB = 17'(Y_BASE);
  localparam logic [16:0] MB = 17'(MEM_BYTES);
  localparam logic [15:0] YOFF = 16'(Y_BASE);

  logic [15:0] xmem [XW];
  logic [15:0] ymem [YW];

  function automatic logic below_y(input logic [15:0] a);
    return {1'b0, a} < YB;
  endfunction

  function automatic logic in_mem(input logic [15:0] a);
    return {1'b0, a} < MB;
  endfunction

  function automatic logic [YA-1:0] yidx(input logic [15:0] a);
    logic [15:0] off;
    off = a - YOFF;
    return YA'(off[15:1]);
  endfunction

  function automatic logic [15:0] fetch(input logic [15:0] a);
    if (below_y(a)) return xmem[XA'(a[15:1])];
    else if (in_mem(a)) return ymem[yidx(a)];
    else return 16'h0000;
  endfunction

  wire x_bad = dual && x_rd_en && !below_y(x_addr);
  wire y_bad = dual && y_rd_en && below_y(y_addr);
  wire y_go  = dual && y_rd_en;

  wire       lo_we = wr_en && (!wr_byte || !wr_addr[0]);
  wire       hi_we = wr_en && (!wr_byte || wr_addr[0]);
  wire [7:0] hi_d  = wr_byte ? wr_data[7:0] : wr_data[15:8];

  always_ff @(posedge clk) begin
    if (below_y(wr_addr)) begin
      if (lo_we) xmem[XA'(wr_addr[15:1])][7:0]  <= wr_data[7:0];
      if (hi_we) xmem[XA'(wr_addr[15:1])][15:8] <= hi_d;
    end else if (in_mem(wr_addr)) begin
      if (lo_we) ymem[yidx(wr_addr)][7:0]  <= wr_data[7:0];
      if (hi_we) ymem[yidx(wr_addr)][15:8] <= hi_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_rdata    <= '0;
      y_rdata    <= '0;
      addr_error <= 1'b0;
    end else begin
      if (x_rd_en) x_rdata <= x_bad ? 16'h0000 : fetch(x_addr);
      if (y_go)    y_rdata <= y_bad ? 16'h0000 : fetch(y_addr);
      addr_error <= x_bad || y_bad;
    end
  end

  p_xfault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dual && x_rd_en && {1'b0, x_addr} >= YB) |=> (addr_error && x_rdata == 16'h0000));
  p_yfault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dual && y_rd_en && {1'b0, y_addr} < YB) |=> (addr_error && y_rdata == 16'h0000));
  p_noerr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dual |=> !addr_error);
  p_above_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (x_rd_en && {1'b0, x_addr} >= MB) |=> x_rdata == 16'h0000);
  p_xhold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !x_rd_en |=> $stable(x_rdata));
  p_yhold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dual && y_rd_en) |=> $stable(y_rdata));
endmodule

// File: tb/tb_xy_data_mem.sv
`timescale 1ns/1ps
module tb_xy_data_mem;
  localparam int MEM_BYTES = 4096;
  localparam int Y_BASE    = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dual = 1'b0, x_rd_en = 1'b0, y_rd_en = 1'b0;
  logic        wr_en = 1'b0, wr_byte = 1'b0;
  logic [15:0] x_addr = '0, y_addr = '0, wr_addr = '0, wr_data = '0;
  logic [15:0] x_rdata, y_rdata;
  logic        addr_error;

  int checks = 0, fails = 0;
  logic [15:0] mdl [MEM_BYTES/2];
  logic [15:0] last_x = '0, last_y = '0;

  always #5 clk = ~clk;

  xy_data_mem #(.MEM_BYTES(MEM_BYTES), .Y_BASE(Y_BASE)) dut (
    .clk(clk), .rst_n(rst_n), .dual(dual), .x_rd_en(x_rd_en), .x_addr(x_addr),
    .y_rd_en(y_rd_en), .y_addr(y_addr), .wr_en(wr_en), .wr_byte(wr_byte),
    .wr_addr(wr_addr), .wr_data(wr_data), .x_rdata(x_rdata), .y_rdata(y_rdata),
    .addr_error(addr_error));

  function automatic logic [15:0] exp_read(input logic [15:0] a);
    if (int'(a) >= MEM_BYTES) return 16'h0000;
    return mdl[int'(a) / 2];
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic op(input string tag, input logic d, input logic xe, input logic [15:0] xa,
                    input logic ye, input logic [15:0] ya, input logic we, input logic wb,
                    input logic [15:0] wa, input logic [15:0] wd);
    logic [15:0] ex, ey;
    logic ee;
    @(negedge clk);
    dual = d; x_rd_en = xe; x_addr = xa; y_rd_en = ye; y_addr = ya;
    wr_en = we; wr_byte = wb; wr_addr = wa; wr_data = wd;
    ee = d && ((xe && int'(xa) >= Y_BASE) || (ye && int'(ya) < Y_BASE));
    ex = !xe ? last_x : ((d && int'(xa) >= Y_BASE) ? 16'h0000 : exp_read(xa));
    ey = !(d && ye) ? last_y : ((int'(ya) < Y_BASE) ? 16'h0000 : exp_read(ya));
    @(posedge clk);
    #1;
    chk(tag, "x_rdata", x_rdata, ex);
    chk(tag, "y_rdata", y_rdata, ey);
    chk(tag, "addr_error", {15'd0, addr_error}, {15'd0, ee});
    last_x = ex; last_y = ey;
    if (we && int'(wa) < MEM_BYTES) begin
      if (!wb) mdl[int'(wa) / 2] = wd;
      else if (wa[0]) mdl[int'(wa) / 2][15:8] = wd[7:0];
      else mdl[int'(wa) / 2][7:0] = wd[7:0];
    end
  endtask

  function automatic logic [15:0] rand_addr();
    case ($urandom_range(3, 0))
      0: return 16'($urandom_range(Y_BASE - 1, 0));
      1: return 16'($urandom_range(MEM_BYTES - 1, Y_BASE));
      2: return 16'($urandom_range(65535, MEM_BYTES));
      default: return 16'($urandom_range(8191, 0));
    endcase
  endfunction

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "x_rdata in reset", x_rdata, 16'h0000);
    chk("R1", "addr_error in reset", {15'd0, addr_error}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "y_rdata after reset", y_rdata, 16'h0000);

    for (int w = 0; w < MEM_BYTES / 2; w++)
      op("R3", 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, 16'(w * 2), 16'($urandom));

    op("R2", 1'b0, 1'b1, 16'd101, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0);
    op("R2", 1'b0, 1'b1, 16'(Y_BASE + 7), 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0);
    op("R3", 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0203, 16'hBEEF);
    op("R3", 1'b0, 1'b1, 16'h0202, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0);
    op("R4", 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b1, 16'h0300, 16'hAA11);
    op("R4", 1'b0, 1'b1, 16'h0300, 1'b0, 16'h0, 1'b1, 1'b1, 16'h0301, 16'hBB22);
    op("R4", 1'b0, 1'b1, 16'h0301, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0);
    op("R4", 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b1, 16'(Y_BASE + 9), 16'h0077);
    op("R4", 1'b0, 1'b1, 16'(Y_BASE + 8), 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0);
    op("R5", 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, 16'(MEM_BYTES + 20), 16'hDEAD);
    op("R5", 1'b0, 1'b1, 16'd20, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0);
    op("R5", 1'b0, 1'b1, 16'(MEM_BYTES + 20), 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0);
    op("R6", 1'b1, 1'b1, 16'd10, 1'b1, 16'(Y_BASE + 10), 1'b0, 1'b0, 16'h0, 16'h0);
    op("R6", 1'b1, 1'b1, 16'(Y_BASE - 2), 1'b1, 16'(MEM_BYTES - 2), 1'b0, 1'b0, 16'h0, 16'h0);
    op("R7", 1'b1, 1'b1, 16'(Y_BASE + 4), 1'b1, 16'(Y_BASE + 12), 1'b0, 1'b0, 16'h0, 16'h0);
    op("R7", 1'b1, 1'b1, 16'd30, 1'b1, 16'(Y_BASE - 1), 1'b0, 1'b0, 16'h0, 16'h0);
    op("R7", 1'b1, 1'b1, 16'd40, 1'b1, 16'(Y_BASE + 40), 1'b0, 1'b0, 16'h0, 16'h0);
    op("R8", 1'b0, 1'b1, 16'h0040, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0041, 16'h5A5A);
    op("R8", 1'b0, 1'b1, 16'h0040, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0);
    op("R8", 1'b1, 1'b0, 16'h0, 1'b1, 16'(Y_BASE + 2), 1'b1, 1'b0, 16'(Y_BASE + 2), 16'h1234);
    op("R9", 1'b0, 1'b0, 16'd200, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0);
    op("R9", 1'b0, 1'b0, 16'd300, 1'b1, 16'(Y_BASE + 50), 1'b0, 1'b0, 16'h0, 16'h0);

    for (int i = 0; i < 3000; i++) begin
      logic d;
      d = ($urandom_range(1, 0) == 1);
      op(d ? "R6/R7" : "R2/R5", d, ($urandom_range(3, 0) != 0), rand_addr(),
         ($urandom_range(3, 0) != 0), rand_addr(), ($urandom_range(1, 0) == 1),
         ($urandom_range(1, 0) == 1), rand_addr(), 16'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule